// File: doc/BRIEF.md
# Serial CRC-32 Engine for Variable-Length Messages

This block works out an Ethernet-style 32-bit cyclic redundancy check one bit per clock, in step with a serial transfer. Before each message the user pulses a start strobe together with the message length, which can be 12 to 64 bits, and a mode bit. Data bits then arrive with a valid qualifier. The engine counts them down itself, so it never keeps a copy of the message and never adds zero padding. The check value is ready in the cycle after the last bit.

In generate mode the engine absorbs exactly the stated number of message bits. It then presents the complemented register as the frame check value for the transmitter. In check mode it also absorbs the 32 received check bits that follow the message. At the end it reports whether the register holds the fixed good-frame residue.

Top module: `bitcrc32_engine`

## Requirements
- R1: While reset is low at a clock edge, and in the cycle that follows, fcs_o reads 0x00000000 and done_o and match_o read 0.
- R2: A start strobe loads the register with all ones, so fcs_o reads 0x00000000 in the next cycle. It also latches the length and mode. A data bit offered in the same cycle as the strobe is not absorbed.
- R3: Each absorbed bit b updates the register s as follows: fb = s[0] xor b, then s becomes (s >> 1) xor (fb ? 0xEDB88320 : 0). This is the reflected 0x04C11DB7 polynomial, fed least significant bit first. The first bit of a message is bit 0 of the message word.
- R4: fcs_o is always the bitwise complement of the register. When done_o is high in generate mode, fcs_o equals the CRC-32 of the message bits.
- R5: In generate mode (mode_chk_i = 0), for any length from 12 to 64, done_o is high in the cycle after the edge that absorbs the last message bit.
- R6: In check mode (mode_chk_i = 1), the engine absorbs len_i message bits and then 32 check bits. The check bits are the complemented CRC, sent least significant bit first. done_o follows the last of these len_i + 32 bits.
- R7: match_o is high only while done_o is high, in a check-mode message, and when the register equals 0xDEBB20E3. A frame with one flipped bit gives match_o = 0.
- R8: A bit with bit_vld_i low is not absorbed. A valid bit that arrives while no message is active is also not absorbed: fcs_o keeps its value.
- R9: A start strobe during an active message abandons that message and begins a new one with the new length and mode.
- R10: done_o lasts exactly one cycle. No further done_o appears until another start strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Begins a message; loads all ones and latches length and mode |
| len_i | input | 7 | Message length in bits, 12 to 64 |
| mode_chk_i | input | 1 | 0 = generate, 1 = check (32 check bits follow the message) |
| bit_i | input | 1 | Serial data bit |
| bit_vld_i | input | 1 | Qualifies bit_i |
| fcs_o | output | 32 | Complement of the CRC register |
| done_o | output | 1 | One-cycle pulse after the final bit |
| match_o | output | 1 | Good-frame flag in check mode, valid with done_o |

## Verification
Two functions can fall in the same clock edge: a new start strobe and the absorption of a valid bit of the message in flight. The bench provokes this by raising start_i and bit_vld_i together in the middle of a 40-bit message, with bit_i set to 1. It judges the outcome at the ports. In the next cycle fcs_o must read zero, which shows the register was loaded and the bit was not absorbed. The 12-bit message that follows must then finish with the value a bench model computes for that message alone. The bench checks random lengths over the whole range, with idle gaps, in both modes, and with single-bit corruptions in check mode, against a bitwise software model.

// File: rtl/bitcrc32_pkg.sv
// Shared constants for the serial CRC-32 engine.
// Assumes the reflected (LSB-first) form of the Ethernet polynomial.
package bitcrc32_pkg;
    localparam int          CRC_W      = 32;
    localparam logic [31:0] POLY_REFL  = 32'hEDB88320;
    localparam logic [31:0] GOOD_RESID = 32'hDEBB20E3;

    typedef enum logic {
        MODE_GEN = 1'b0,
        MODE_CHK = 1'b1
    } crc_mode_e;
endpackage

// File: rtl/bitcrc32_lfsr.sv
// One-bit-per-clock CRC shift register, reflected form.
// Assumes load has priority over shift; holds its value when neither is set.
module bitcrc32_lfsr #(
    parameter int          W    = 32,
    parameter logic [W-1:0] POLY = 32'hEDB88320
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic         shift_i,
    input  logic         bit_i,
    output logic [W-1:0] state_o
);
    logic [W-1:0] state_q;
    logic [W-1:0] nxt;
    logic         fb;

    // next value when one bit is absorbed
    always_comb begin
        fb  = state_q[0] ^ bit_i;
        nxt = (state_q >> 1) ^ (fb ? POLY : '0);
    end

    // register: preload on load, update on shift
    always_ff @(posedge clk) begin
        if (!rst_n)       state_q <= '1;
        else if (load_i)  state_q <= '1;
        else if (shift_i) state_q <= nxt;
    end

    assign state_o = state_q;

    a_r2_load_ones: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> state_q == '1);
    a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !shift_i) |=> $stable(state_q));
    a_r3_top_feedback: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_i && !load_i) |=>
        state_q[W-1] == (POLY[W-1] & ($past(state_q[0]) ^ $past(bit_i))));
endmodule

// File: rtl/bitcrc32_seq.sv
// Message sequencer: counts absorbed bits down from the length
// (plus the check width in check mode) and pulses done after the last.
// Assumes lengths of at least 1; start aborts any message in flight.
module bitcrc32_seq #(
    parameter int MAX_LEN = 64,
    parameter int CRC_W   = 32,
    localparam int LEN_W  = $clog2(MAX_LEN + 1),
    localparam int CNT_W  = $clog2(MAX_LEN + CRC_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic             chk_i,
    input  logic             vld_i,
    output logic             take_o,
    output logic             done_o,
    output logic             chk_o
);
    logic             busy_q;
    logic             done_q;
    logic             chk_q;
    logic [CNT_W-1:0] cnt_q;

    // a bit is absorbed only inside a message and never on a start cycle
    assign take_o = busy_q && vld_i && !start_i;

    // bit counter, activity flag and done pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            chk_q  <= 1'b0;
            cnt_q  <= '0;
        end else begin
            done_q <= 1'b0;
            if (start_i) begin
                busy_q <= 1'b1;
                chk_q  <= chk_i;
                cnt_q  <= CNT_W'(len_i) + (chk_i ? CNT_W'(CRC_W) : '0);
            end else if (take_o) begin
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CNT_W'(1)) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign done_o = done_q;
    assign chk_o  = chk_q;

    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);
    a_r9_start_arms: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (busy_q && !done_q));
    a_r5_done_after_bit: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> $past(take_o));
endmodule

// File: rtl/bitcrc32_engine.sv
// Top: serial CRC-32 generator/checker for 12..64-bit messages.
// Assumes len_i is within range when start_i is pulsed.
module bitcrc32_engine
    import bitcrc32_pkg::*;
#(
    parameter int MAX_LEN = 64,
    localparam int LEN_W  = $clog2(MAX_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic             mode_chk_i,
    input  logic             bit_i,
    input  logic             bit_vld_i,
    output logic [31:0]      fcs_o,
    output logic             done_o,
    output logic             match_o
);
    logic             take;
    logic             chk_lat;
    logic [CRC_W-1:0] state;

    bitcrc32_seq #(.MAX_LEN(MAX_LEN), .CRC_W(CRC_W)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .len_i   (len_i),
        .chk_i   (mode_chk_i),
        .vld_i   (bit_vld_i),
        .take_o  (take),
        .done_o  (done_o),
        .chk_o   (chk_lat)
    );

    bitcrc32_lfsr #(.W(CRC_W), .POLY(POLY_REFL)) u_lfsr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (start_i),
        .shift_i (take),
        .bit_i   (bit_i),
        .state_o (state)
    );

    // outputs: complemented register and residue judgement
    always_comb begin
        fcs_o   = ~state;
        match_o = done_o && (crc_mode_e'(chk_lat) == MODE_CHK) && (state == GOOD_RESID);
    end

    a_r7_match_check_only: assert property (@(posedge clk) disable iff (!rst_n)
        match_o |-> (done_o && $past(take)));
endmodule

// File: tb/sim_bitcrc32_engine.sv
module sim_bitcrc32_engine;
    logic        clk = 1'b0;
    logic        rst_n, start_i, mode_chk_i, bit_i, bit_vld_i;
    logic [6:0]  len_i;
    logic [31:0] fcs_o;
    logic        done_o, match_o;
    int          n_chk = 0, n_fail = 0;
    bit          finished = 1'b0;

    always #5 clk = ~clk;

    bitcrc32_engine u0 (.clk(clk), .rst_n(rst_n), .start_i(start_i), .len_i(len_i),
        .mode_chk_i(mode_chk_i), .bit_i(bit_i), .bit_vld_i(bit_vld_i),
        .fcs_o(fcs_o), .done_o(done_o), .match_o(match_o));

    function automatic logic [31:0] crc_run(logic [31:0] s, int n, logic [127:0] d);
        for (int i = 0; i < n; i++) begin
            logic fb;
            fb = s[0] ^ d[i];
            s  = s >> 1;
            if (fb) s = s ^ 32'hEDB88320;
        end
        return s;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic begin_msg(int len, bit chk, bit vld, bit b);
        @(negedge clk);
        start_i = 1'b1; len_i = 7'(len); mode_chk_i = chk; bit_vld_i = vld; bit_i = b;
        @(negedge clk);
        start_i = 1'b0; bit_vld_i = 1'b0;
    endtask

    // feeds n bits of d; leaves us at the negedge after the last bit's edge
    task automatic feed(logic [127:0] d, int n, int gap_pct);
        for (int i = 0; i < n; i++) begin
            if (int'($urandom % 100) < gap_pct) begin
                bit_vld_i = 1'b0; bit_i = $urandom; @(negedge clk);
            end
            bit_vld_i = 1'b1; bit_i = d[i];
            @(negedge clk);
        end
        bit_vld_i = 1'b0;
    endtask

    task automatic run_msg(int len, logic [63:0] data, bit chk, int flip, int gap);
        logic [127:0] d;
        int           total;
        logic [31:0]  resid;
        d = '0;
        d[63:0] = data;
        for (int i = len; i < 64; i++) d[i] = 1'b0;
        if (chk) d[len +: 32] = ~crc_run('1, len, d);
        total = len + (chk ? 32 : 0);
        if (flip >= 0) d[flip] = ~d[flip];
        begin_msg(len, chk, 1'b0, 1'b0);
        check("R2 fcs after start", fcs_o, 32'h0);
        feed(d, total, gap);
        resid = crc_run('1, total, d);
        check(chk ? "R6 done after len+32" : "R5 done after len", 32'(done_o), 32'h1);
        check("R4 fcs value", fcs_o, ~resid);
        check("R7 match", 32'(match_o), 32'(chk && flip < 0));
        @(negedge clk);
        check("R10 done single", 32'(done_o), 32'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %h expected %h", 32'h1, 32'h0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [127:0] d;
        logic [31:0]  hold;
        void'($urandom(32'd20240611));
        rst_n = 1'b0; start_i = 1'b0; len_i = '0; mode_chk_i = 1'b0;
        bit_i = 1'b0; bit_vld_i = 1'b0;
        repeat (5) @(negedge clk);
        check("R1 reset fcs", fcs_o, 32'h0);
        check("R1 reset done", 32'(done_o), 32'h0);
        check("R1 reset match", 32'(match_o), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R8: valid bits with no message active
        for (int i = 0; i < 4; i++) begin
            bit_vld_i = 1'b1; bit_i = 1'b1; @(negedge clk);
        end
        bit_vld_i = 1'b0;
        check("R8 idle bits ignored", fcs_o, 32'h0);

        // directed boundaries
        run_msg(12, 64'hABC, 1'b0, -1, 0);
        run_msg(64, 64'h0123456789ABCDEF, 1'b0, -1, 0);
        run_msg(12, 64'h5A5, 1'b1, -1, 0);
        run_msg(64, 64'hFFFFFFFF00000000, 1'b1, -1, 0);
        run_msg(33, 64'h1_2345_6789, 1'b1, 40, 0);
        run_msg(20, 64'hF0F0F, 1'b0, -1, 60);

        // R8/R10: bits after done without start: no change, no done
        hold = fcs_o;
        for (int i = 0; i < 5; i++) begin
            bit_vld_i = 1'b1; bit_i = i[0]; @(negedge clk);
            check("R10 no done without start", 32'(done_o), 32'h0);
        end
        bit_vld_i = 1'b0;
        check("R8 fcs held when idle", fcs_o, hold);

        // R9: abort mid-message; start coincides with a valid bit
        d = {64'h0, 64'hDEADBEEFCAFE};
        begin_msg(40, 1'b0, 1'b0, 1'b0);
        feed(d, 20, 0);
        check("R9 no done mid-message", 32'(done_o), 32'h0);
        begin_msg(12, 1'b0, 1'b1, 1'b1);
        check("R9 R2 restart reloads ones", fcs_o, 32'h0);
        d = {64'h0, 64'h9C3};
        feed(d, 12, 0);
        check("R9 restart done", 32'(done_o), 32'h1);
        check("R9 restart fcs", fcs_o, ~crc_run('1, 12, d));
        @(negedge clk);

        // constrained random over the whole length range
        for (int k = 0; k < 40; k++) begin
            int  len;
            bit  chk;
            int  flip;
            len  = 12 + int'($urandom % 53);
            chk  = $urandom;
            flip = (chk && ($urandom % 3 == 0)) ? int'($urandom % (len + 32)) : -1;
            run_msg(len, {$urandom, $urandom}, chk, flip, 20);
        end

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule